// File: doc/BRIEF.md
# Auto-Incrementing RAM Door Port

This block gives a host processor direct byte and 16-bit word access to a shared byte-addressed data RAM. Access goes through one data "door" register. FIFO partitioning plays no part, so any RAM location can be reached. To write, the host loads a start address into the write-pointer register and then writes the door as many times as needed. After each access the pointer moves forward by the number of bytes that access carried. Runs of consecutive bytes therefore need no further address writes.

To read, the host loads a start address and a byte count, then triggers the read function. The function runs in the background, one byte per cycle. It fetches bytes from the RAM into a small result buffer and moves its own address and count registers forward as it goes. While it runs, those registers are locked against host writes and their read values are not meaningful. When it finishes, it sets a completion flag in the interrupt status register. The flag is cleared by writing 1 to it, and it drives an interrupt line when enabled.

The host bus is a plain set of strobes: a register index, byte enables, write data and a registered read-data return.

Top module: `door_port`

## Requirements
- R1: After reset, the write pointer, read address, read count, completion flag, interrupt enable, `host_rdata` and `irq` are all zero.
- R2: Register index 0 holds the write pointer. Byte lane 0 (`host_wdata[7:0]`) writes the low byte and lane 1 (`host_wdata[15:8]`) writes the high byte. Each lane is updated only when its enable is set. Only the low ADDR_W bits are kept, and the upper bits read as zero.
- R3: A write to index 1 (the door) with `host_be`=11 stores `wdata[7:0]` at pointer P and `wdata[15:8]` at P+1, then advances the pointer by 2. With `host_be`=01 it stores `wdata[7:0]` at P and advances by 1. With `host_be`=10 it stores `wdata[15:8]` at P and advances by 1. With `host_be`=00 nothing changes.
- R4: The write pointer and the read address wrap from the top RAM byte to address 0, and so does the second byte of a word access.
- R5: Index 2 holds the read address (lanes as in R2) and index 3 bits 7:0 hold the read count. Writing index 4 with bit 0 = 1 (lane 0 enabled) starts the read function. Byte i of the run comes from address start+i. It lands in buffer register 8+i/2, in lane 0 when i is even and in lane 1 when i is odd. At completion the read address equals start+count and the count is 0.
- R6: The completion flag (index 5, bit 0) sets at the (count+1)-th rising edge after the edge that accepted the start. Writing 1 to it through lane 0 clears it. A set in the same cycle as a clear wins.
- R7: `irq` is high exactly while the completion flag and the enable bit (index 6, bit 0) are both 1.
- R8: A start with count 0 sets the completion flag at the next edge and leaves the buffer unchanged.
- R9: While the read function runs, host writes to indices 2, 3 and 4 are ignored.
- R10: A count written above BUF_BYTES is stored as BUF_BYTES.
- R11: A host read returns its value on `host_rdata` after the next rising edge and holds it until the next read. Indices 1, 4 and unused indices read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_idx | input | 4 | Register index |
| host_be | input | 2 | Byte-lane enables |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| irq | output | 1 | Completion interrupt |

## Verification
A register read is due one edge after the read strobe is sampled. A write-pointer step and a door store are due at the edge that samples the write. The completion flag is due exactly count+1 edges after the start edge. The bench drives the bus on falling edges and runs a behavioural model that steps on the same rising edges, with its own countdown for completion. On every falling edge it compares `irq` with the model, so an early or late flag is caught in the exact cycle. It also compares `host_rdata` in the cycle after each read. Buffer contents, the read address and the read count are checked only after completion, because their values in flight are undefined.

// File: rtl/door_pkg.sv
package door_pkg;
    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] IDX_WPTR  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_DOOR  = 4'd1;
    localparam logic [IDX_W-1:0] IDX_RADDR = 4'd2;
    localparam logic [IDX_W-1:0] IDX_RCNT  = 4'd3;
    localparam logic [IDX_W-1:0] IDX_GO    = 4'd4;
    localparam logic [IDX_W-1:0] IDX_STAT  = 4'd5;
    localparam logic [IDX_W-1:0] IDX_IEN   = 4'd6;
    localparam logic [IDX_W-1:0] IDX_BUF0  = 4'd8;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_RUN   = 2'd1,
        RD_DRAIN = 2'd2
    } rd_state_e;
endpackage

// File: rtl/door_ram.sv
module door_ram #(
    parameter int ADDR_W = 10,
    localparam int BYTES = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we0,
    input  logic [ADDR_W-1:0] waddr0,
    input  logic [7:0]        wdata0,
    input  logic              we1,
    input  logic [ADDR_W-1:0] waddr1,
    input  logic [7:0]        wdata1,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem_q [BYTES];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we0) mem_q[waddr0] <= wdata0;
        if (we1) mem_q[waddr1] <= wdata1;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/door_wr_seq.sv
module door_wr_seq #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              door_we,
    input  logic [1:0]        be,
    input  logic [15:0]       wdata,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              ram_we0,
    output logic [ADDR_W-1:0] ram_waddr0,
    output logic [7:0]        ram_wdata0,
    output logic              ram_we1,
    output logic [ADDR_W-1:0] ram_waddr1,
    output logic [7:0]        ram_wdata1
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [15:0] ptr_wide;

    always_comb begin
        st_d       = st_q;
        ptr_wide   = 16'(st_q.ptr);
        ram_we0    = 1'b0;
        ram_we1    = 1'b0;
        ram_waddr0 = st_q.ptr;
        ram_waddr1 = st_q.ptr + ADDR_W'(1);
        ram_wdata0 = wdata[7:0];
        ram_wdata1 = wdata[15:8];
        if (ptr_we) begin
            if (be[0]) ptr_wide[7:0]  = wdata[7:0];
            if (be[1]) ptr_wide[15:8] = wdata[15:8];
            st_d.ptr = ptr_wide[ADDR_W-1:0];
        end else if (door_we) begin
            case (be)
                2'b11: begin
                    ram_we0  = 1'b1;
                    ram_we1  = 1'b1;
                    st_d.ptr = st_q.ptr + ADDR_W'(2);
                end
                2'b01: begin
                    ram_we0  = 1'b1;
                    st_d.ptr = st_q.ptr + ADDR_W'(1);
                end
                2'b10: begin
                    ram_we0    = 1'b1;
                    ram_wdata0 = wdata[15:8];
                    st_d.ptr   = st_q.ptr + ADDR_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr = st_q.ptr;

    // R3: the pointer steps by the size of each door access
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (door_we && !ptr_we && be != 2'b00) |=>
            wr_ptr == $past(wr_ptr) + (($past(be) == 2'b11) ? ADDR_W'(2) : ADDR_W'(1)));

    // R3: a door access with no lanes enabled leaves the pointer alone
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (door_we && !ptr_we && be == 2'b00) |=> $stable(wr_ptr));
endmodule

// File: rtl/door_rd_engine.sv
module door_rd_engine import door_pkg::*; #(
    parameter int ADDR_W    = 10,
    parameter int BUF_BYTES = 8,
    localparam int CNT_W = $clog2(BUF_BYTES + 1),
    localparam int BI_W  = $clog2(BUF_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   addr_we,
    input  logic                   cnt_we,
    input  logic                   go_we,
    input  logic [1:0]             be,
    input  logic [15:0]            wdata,
    input  logic [7:0]             ram_rdata,
    output logic [ADDR_W-1:0]      ram_raddr,
    output logic [ADDR_W-1:0]      rd_addr,
    output logic [CNT_W-1:0]       rd_cnt,
    output logic                   done_pulse,
    output logic [8*BUF_BYTES-1:0] buf_flat
);
    typedef struct packed {
        rd_state_e                   state;
        logic [ADDR_W-1:0]           addr;
        logic [CNT_W-1:0]            cnt;
        logic [BI_W-1:0]             idx;
        logic                        pend;
        logic [BI_W-1:0]             pidx;
        logic [BUF_BYTES-1:0][7:0]   data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [15:0] addr_wide;
    logic        go_req;

    assign go_req = go_we && be[0] && wdata[0];

    always_comb begin
        st_d       = st_q;
        done_pulse = 1'b0;
        addr_wide  = 16'(st_q.addr);
        if (st_q.pend) st_d.data[st_q.pidx] = ram_rdata;
        st_d.pend = 1'b0;
        case (st_q.state)
            RD_IDLE: begin
                if (addr_we) begin
                    if (be[0]) addr_wide[7:0]  = wdata[7:0];
                    if (be[1]) addr_wide[15:8] = wdata[15:8];
                    st_d.addr = addr_wide[ADDR_W-1:0];
                end
                if (cnt_we && be[0]) begin
                    st_d.cnt = (wdata[7:0] > 8'(BUF_BYTES)) ? CNT_W'(BUF_BYTES)
                                                            : CNT_W'(wdata[7:0]);
                end
                if (go_req) begin
                    st_d.idx   = '0;
                    st_d.state = (st_q.cnt == '0) ? RD_DRAIN : RD_RUN;
                end
            end
            RD_RUN: begin
                st_d.pend = 1'b1;
                st_d.pidx = st_q.idx;
                st_d.idx  = st_q.idx + BI_W'(1);
                st_d.addr = st_q.addr + ADDR_W'(1);
                st_d.cnt  = st_q.cnt - CNT_W'(1);
                if (st_q.cnt == CNT_W'(1)) st_d.state = RD_DRAIN;
            end
            RD_DRAIN: begin
                done_pulse = 1'b1;
                st_d.state = RD_IDLE;
            end
            default: st_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ram_raddr = st_q.addr;
    assign rd_addr   = st_q.addr;
    assign rd_cnt    = st_q.cnt;
    assign buf_flat  = st_q.data;

    // R5: each running cycle consumes one byte of the count
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RD_RUN) |=> rd_cnt == $past(rd_cnt) - CNT_W'(1));

    // R5: each running cycle moves the read address by one byte
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RD_RUN) |=> rd_addr == $past(rd_addr) + ADDR_W'(1));

    // R8: a start with an empty count completes on the next cycle
    p_zero_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RD_IDLE && go_req && rd_cnt == '0) |=> done_pulse);

    // R9: host writes cannot disturb the count while the function is running
    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RD_DRAIN && cnt_we) |=> rd_cnt == '0);

    // R10: the stored count never exceeds the buffer size
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= CNT_W'(BUF_BYTES));
endmodule

// File: rtl/door_status.sv
module door_status import door_pkg::*; #(
    parameter int ADDR_W    = 10,
    parameter int BUF_BYTES = 8,
    localparam int CNT_W  = $clog2(BUF_BYTES + 1),
    localparam int NWORDS = BUF_BYTES / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stat_we,
    input  logic                   ien_we,
    input  logic                   lane0,
    input  logic                   bit0,
    input  logic                   done_pulse,
    input  logic                   host_rd,
    input  logic [IDX_W-1:0]       host_idx,
    input  logic [ADDR_W-1:0]      wr_ptr,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [CNT_W-1:0]       rd_cnt,
    input  logic [8*BUF_BYTES-1:0] buf_flat,
    output logic [15:0]            host_rdata,
    output logic                   irq
);
    typedef struct packed {
        logic        done;
        logic        ien;
        logic [15:0] rdata;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [15:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        case (host_idx)
            IDX_WPTR:  rd_mux = 16'(wr_ptr);
            IDX_RADDR: rd_mux = 16'(rd_addr);
            IDX_RCNT:  rd_mux = 16'(rd_cnt);
            IDX_STAT:  rd_mux = {15'd0, st_q.done};
            IDX_IEN:   rd_mux = {15'd0, st_q.ien};
            default: begin
                for (int k = 0; k < NWORDS; k++) begin
                    if (host_idx == IDX_BUF0 + IDX_W'(k)) rd_mux = buf_flat[16*k +: 16];
                end
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (host_rd) st_d.rdata = rd_mux;
        if (ien_we && lane0) st_d.ien = bit0;
        if (stat_we && lane0 && bit0) st_d.done = 1'b0;
        if (done_pulse) st_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
    assign irq        = st_q.done & st_q.ien;

    // R6: completion always lands in the status flag
    p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> irq == st_q.ien);

    // R6: write-one-to-clear drops the flag when no completion coincides
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && lane0 && bit0 && !done_pulse) |=> !irq);

    // R11: returned data changes only after a read strobe
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: rtl/door_port.sv
module door_port import door_pkg::*; #(
    parameter int ADDR_W    = 10,
    parameter int BUF_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [3:0]  host_idx,
    input  logic [1:0]  host_be,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        irq
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic                   ptr_we, door_we, raddr_we, rcnt_we, go_we, stat_we, ien_we;
    logic [ADDR_W-1:0]      wr_ptr, rd_addr, ram_raddr, ram_waddr0, ram_waddr1;
    logic [CNT_W-1:0]       rd_cnt;
    logic                   ram_we0, ram_we1, done_pulse;
    logic [7:0]             ram_wdata0, ram_wdata1, ram_rdata;
    logic [8*BUF_BYTES-1:0] buf_flat;

    assign ptr_we   = host_wr && host_idx == IDX_WPTR;
    assign door_we  = host_wr && host_idx == IDX_DOOR;
    assign raddr_we = host_wr && host_idx == IDX_RADDR;
    assign rcnt_we  = host_wr && host_idx == IDX_RCNT;
    assign go_we    = host_wr && host_idx == IDX_GO;
    assign stat_we  = host_wr && host_idx == IDX_STAT;
    assign ien_we   = host_wr && host_idx == IDX_IEN;

    door_wr_seq #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .door_we(door_we),
        .be(host_be), .wdata(host_wdata), .wr_ptr(wr_ptr),
        .ram_we0(ram_we0), .ram_waddr0(ram_waddr0), .ram_wdata0(ram_wdata0),
        .ram_we1(ram_we1), .ram_waddr1(ram_waddr1), .ram_wdata1(ram_wdata1)
    );

    door_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we0(ram_we0), .waddr0(ram_waddr0), .wdata0(ram_wdata0),
        .we1(ram_we1), .waddr1(ram_waddr1), .wdata1(ram_wdata1),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    door_rd_engine #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr_we(raddr_we), .cnt_we(rcnt_we),
        .go_we(go_we), .be(host_be), .wdata(host_wdata), .ram_rdata(ram_rdata),
        .ram_raddr(ram_raddr), .rd_addr(rd_addr), .rd_cnt(rd_cnt),
        .done_pulse(done_pulse), .buf_flat(buf_flat)
    );

    door_status #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_stat (
        .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .ien_we(ien_we),
        .lane0(host_be[0]), .bit0(host_wdata[0]), .done_pulse(done_pulse),
        .host_rd(host_rd), .host_idx(host_idx), .wr_ptr(wr_ptr),
        .rd_addr(rd_addr), .rd_cnt(rd_cnt), .buf_flat(buf_flat),
        .host_rdata(host_rdata), .irq(irq)
    );

    // R4: the second byte of a word store wraps with the pointer
    p_word_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we1 |-> ram_waddr1 == ram_waddr0 + ADDR_W'(1));
endmodule

// File: tb/test_door_port.sv
module test_door_port;
    localparam int SZ  = 1024;
    localparam int BUF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_idx = '0;
    logic [1:0]  host_be = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq;

    door_port #(.ADDR_W(10), .BUF_BYTES(BUF)) i_door_port (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_idx(host_idx), .host_be(host_be), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_vec = 0, n_err = 0;
    logic [7:0]  m_ram [SZ];
    logic [7:0]  m_buf [BUF];
    int          m_wptr, m_raddr, m_cnt, m_timer;
    bit          m_done, m_ien, m_busy, m_rvalid;
    logic [15:0] m_rdata;
    string       cur_tag = "R1", m_tag = "R1";

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] m_reg(logic [3:0] idx);
        case (idx)
            4'd0: return 16'(m_wptr);
            4'd2: return 16'(m_raddr);
            4'd3: return 16'(m_cnt);
            4'd5: return {15'd0, m_done};
            4'd6: return {15'd0, m_ien};
            4'd8, 4'd9, 4'd10, 4'd11: begin
                int k = int'(idx) - 8;
                return {m_buf[2*k+1], m_buf[2*k]};
            end
            default: return 16'd0;
        endcase
    endfunction

    // behavioural reference, stepped on the same edges as the design
    always @(posedge clk) begin : model
        bit was_busy;
        logic [15:0] v;
        if (!rst_n) begin
            m_wptr = 0; m_raddr = 0; m_cnt = 0; m_timer = 0;
            m_done = 0; m_ien = 0; m_busy = 0; m_rvalid = 0; m_rdata = '0;
            for (int i = 0; i < BUF; i++) m_buf[i] = 8'h00;
        end else begin
            was_busy = m_busy;
            if (host_rd) begin
                m_rdata = m_reg(host_idx); m_rvalid = 1; m_tag = cur_tag;
            end else m_rvalid = 0;
            if (host_wr && host_idx == 4'd5 && host_be[0] && host_wdata[0]) m_done = 0;
            if (m_timer > 0) begin
                m_timer--;
                if (m_timer == 0) begin m_done = 1; m_busy = 0; end
            end
            if (host_wr) begin
                case (host_idx)
                    4'd0: begin
                        v = 16'(m_wptr);
                        if (host_be[0]) v[7:0] = host_wdata[7:0];
                        if (host_be[1]) v[15:8] = host_wdata[15:8];
                        m_wptr = int'(v) % SZ;
                    end
                    4'd1: begin
                        if (host_be == 2'b11) begin
                            m_ram[m_wptr] = host_wdata[7:0];
                            m_ram[(m_wptr + 1) % SZ] = host_wdata[15:8];
                            m_wptr = (m_wptr + 2) % SZ;
                        end else if (host_be == 2'b01) begin
                            m_ram[m_wptr] = host_wdata[7:0];
                            m_wptr = (m_wptr + 1) % SZ;
                        end else if (host_be == 2'b10) begin
                            m_ram[m_wptr] = host_wdata[15:8];
                            m_wptr = (m_wptr + 1) % SZ;
                        end
                    end
                    4'd2: if (!was_busy) begin
                        v = 16'(m_raddr);
                        if (host_be[0]) v[7:0] = host_wdata[7:0];
                        if (host_be[1]) v[15:8] = host_wdata[15:8];
                        m_raddr = int'(v) % SZ;
                    end
                    4'd3: if (!was_busy && host_be[0])
                        m_cnt = (host_wdata[7:0] > BUF) ? BUF : int'(host_wdata[7:0]);
                    4'd4: if (!was_busy && host_be[0] && host_wdata[0]) begin
                        for (int i = 0; i < m_cnt; i++) m_buf[i] = m_ram[(m_raddr + i) % SZ];
                        m_raddr = (m_raddr + m_cnt) % SZ;
                        m_timer = m_cnt + 1;
                        m_cnt = 0;
                        m_busy = 1;
                    end
                    4'd6: if (host_be[0]) m_ien = host_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle compare away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            // R7 (completion timing of R6 and R8 shows up here cycle by cycle)
            chk(irq == (m_done & m_ien), "R7 irq", {15'd0, irq}, {15'd0, m_done & m_ien});
            if (m_rvalid) chk(host_rdata == m_rdata, m_tag, host_rdata, m_rdata);
        end
    end

    task automatic bus_wr(logic [3:0] idx, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_idx = idx; host_be = be; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_be = 2'b00;
    endtask

    task automatic bus_rd(logic [3:0] idx, string tag);
        @(negedge clk);
        cur_tag = tag; host_rd = 1'b1; host_idx = idx;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_vec++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the port and through reads
        chk(host_rdata == 16'h0 && irq == 1'b0, "R1 outputs", host_rdata, 16'h0);
        bus_rd(4'd0, "R1 wptr");
        bus_rd(4'd2, "R1 raddr");
        bus_rd(4'd3, "R1 rcnt");
        bus_rd(4'd5, "R1 stat");
        bus_rd(4'd6, "R1 ien");
        bus_wr(4'd6, 2'b01, 16'h0001);

        // R2: pointer lanes and width
        bus_wr(4'd0, 2'b11, 16'h0123); bus_rd(4'd0, "R2 word");
        bus_wr(4'd0, 2'b11, 16'hFFFF); bus_rd(4'd0, "R2 masked");
        bus_wr(4'd0, 2'b10, 16'h0200); bus_rd(4'd0, "R2 high lane");

        // R3: word and byte door writes, empty enables
        bus_wr(4'd0, 2'b11, 16'h0010);
        bus_wr(4'd1, 2'b11, 16'hBBAA);
        bus_wr(4'd1, 2'b01, 16'h00CC);
        bus_wr(4'd1, 2'b10, 16'hDD00);
        bus_wr(4'd1, 2'b00, 16'h1234);
        bus_wr(4'd1, 2'b11, 16'hFFEE);
        bus_rd(4'd0, "R3 pointer");
        bus_wr(4'd1, 2'b11, 16'h4433);

        // R5 and R9: six-byte run with writes attempted while busy
        bus_wr(4'd2, 2'b11, 16'h0010);
        bus_wr(4'd3, 2'b01, 16'h0006);
        bus_wr(4'd4, 2'b01, 16'h0001);
        bus_wr(4'd2, 2'b11, 16'h0300);
        bus_wr(4'd3, 2'b01, 16'h0002);
        bus_wr(4'd4, 2'b01, 16'h0001);
        repeat (10) @(negedge clk);
        bus_rd(4'd8, "R5 buf0");
        bus_rd(4'd9, "R5 buf1");
        bus_rd(4'd10, "R5 buf2");
        bus_rd(4'd2, "R9 raddr");
        bus_rd(4'd3, "R9 rcnt");
        bus_rd(4'd5, "R6 stat set");
        bus_wr(4'd5, 2'b01, 16'h0001);
        bus_rd(4'd5, "R6 stat cleared");

        // R4: wrap of pointer, word store and read address
        bus_wr(4'd0, 2'b11, 16'h03FF);
        bus_wr(4'd1, 2'b11, 16'h2211);
        bus_rd(4'd0, "R4 wptr");
        bus_wr(4'd2, 2'b11, 16'h03FF);
        bus_wr(4'd3, 2'b01, 16'h0002);
        bus_wr(4'd4, 2'b01, 16'h0001);
        repeat (6) @(negedge clk);
        bus_rd(4'd8, "R4 buf0");
        bus_rd(4'd2, "R4 raddr");
        bus_wr(4'd5, 2'b01, 16'h0001);

        // R10: oversized count clamps; full-buffer run
        bus_wr(4'd2, 2'b11, 16'h0010);
        bus_wr(4'd3, 2'b01, 16'h0020);
        bus_rd(4'd3, "R10 clamp");
        bus_wr(4'd4, 2'b01, 16'h0001);
        repeat (12) @(negedge clk);
        for (int r = 8; r < 12; r++) bus_rd(4'(r), "R10 buf");
        bus_wr(4'd5, 2'b01, 16'h0001);

        // R8: empty run completes next cycle, buffer untouched
        bus_wr(4'd4, 2'b01, 16'h0001);
        bus_rd(4'd8, "R8 buf");
        bus_rd(4'd5, "R8 stat");

        // R7: disable masks the interrupt; R11: write-only indices read zero
        bus_wr(4'd6, 2'b01, 16'h0000);
        repeat (2) @(negedge clk);
        bus_rd(4'd1, "R11 door");
        bus_rd(4'd4, "R11 start");
        bus_rd(4'd15, "R11 unused");
        finish_run();
    end
endmodule